// File: doc/BRIEF.md
# Pixel Serializer with Attribute Fetch

This block sits between a screen-memory fetcher and the palette stage of a raster display engine. While the pixel-window enable is high it produces one 4-bit colour index per 16 MHz tick across a 640-slot line. The source is 1-bit-per-pixel bitmap bytes, each holding eight pixels. The block decides when it needs bytes and raises a request pulse for each one. The fetcher answers with a data strobe. Each pixel can be widened to one, two or three ticks. The first eight slots of every line stay dark, and slots left after the last whole column are also dark.

In the widened modes there is a spare memory slot between two bitmap fetches. The block uses it to read an attribute byte for the next character column. Attributes are read only on the first pixel line of a character row and are stored in a small buffer. The other seven lines of the row reuse the buffer. Two attribute layouts exist. In per-cell mode one byte gives a foreground and a background colour for one column. In per-pair mode one byte gives a foreground colour to each of two neighbouring columns, and background pixels use colour 0.

The controller is a five-state machine:
- `ST_IDLE` waits for the enable.
- `ST_LEAD` covers the eight dark lead slots.
- `ST_ACTIVE` emits the columns.
- `ST_PAD` emits dark slots up to slot 639.
- `ST_DONE` holds dark until the enable falls.

The transitions are:
- IDLE→LEAD when the enable is seen high.
- LEAD→ACTIVE at slot 7.
- ACTIVE→PAD at the end of the last column, or ACTIVE→DONE if that end falls on slot 639.
- PAD→DONE at slot 639.
- Any state →IDLE when the enable goes low.

Top module: `pixel_serializer`

## Requirements
- R1: With attributes off, a 1 bit gives colour index 1 and a 0 bit gives index 0. Bits are sent most significant first, so pixel i of a column comes from bit 7−i.
- R2: `scale_sel` sets the width of each pixel: 0 gives 1 tick, 1 gives 2 ticks, and 2 or 3 give 3 ticks. A column therefore spans P = 8×width ticks. Column c starts at slot 8 + c×P.
- R3: Slot 0 is the first tick after the clock edge that sees `line_en` high. Slots 0 to 7 output index 0.
- R4: A line shows floor(632/P) columns: 79, 39 or 26. Every slot after the last column up to 639 outputs 0. Every slot from 640 on also outputs 0 while `line_en` stays high.
- R5: The bitmap request for column k is a one-tick pulse on `bm_req` at slot 4 + k×P. Exactly one request is made per shown column. The strobe carrying the byte must come within three ticks.
- R6: The attribute request for column k is a one-tick pulse on `at_req` at slot k×P. In per-pair mode only even k are requested. Requests happen only on line index 0 and only when width is 2 or 3. `at_req` and `bm_req` are never high in the same tick.
- R7: `attr_sel`=1 selects per-cell mode. Bits [7:4] of the column's attribute give the colour of 1 pixels, and bits [3:0] give the colour of 0 pixels.
- R8: `attr_sel`=2 or 3 selects per-pair mode. Byte j covers columns 2j and 2j+1. A 1 pixel takes bits [7:4] in the even column and bits [3:0] in the odd column. A 0 pixel gives 0.
- R9: On lines with index 1 to 7, colours come from the attributes stored on the last index-0 line. Attribute strobes on those lines are ignored.
- R10: With width 1, attributes are off whatever `attr_sel` is. No attribute request is made and the output follows R1.
- R11: After reset, and from the tick after `line_en` is seen low, the output is 0 and no request is raised. A line cut short leaves no effect on the next line. Mode and line index are captured when the line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz pixel clock |
| rst_n | input | 1 | Active-low reset |
| line_en | input | 1 | Pixel-window enable for the current line |
| scale_sel | input | 2 | Pixel width select (0: ×1, 1: ×2, 2/3: ×3) |
| attr_sel | input | 2 | Attribute mode (0 off, 1 per cell, 2/3 per pair) |
| row_line | input | 3 | Pixel line index within the character row |
| bm_stb | input | 1 | Bitmap byte strobe from the fetcher |
| bm_byte | input | 8 | Bitmap byte |
| at_stb | input | 1 | Attribute byte strobe from the fetcher |
| at_byte | input | 8 | Attribute byte |
| pix_idx | output | 4 | Colour index for the current tick |
| bm_req | output | 1 | Bitmap fetch request pulse |
| at_req | output | 1 | Attribute fetch request pulse |

## Verification
The hardest case to reach is the reuse of stored attributes across a character row. To get there, the bench runs a full index-0 line that fills the buffer. It then runs seven more lines with different bitmap bytes. On one of those lines it drives an attribute strobe with junk data on every tick, so a wrong write would change the colours. This full row is repeated for every width and attribute mode. The bench also cuts one line short and then checks that the next line starts cleanly.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACTIVE,
        ST_PAD,
        ST_DONE
    } pxs_state_t;

    typedef enum logic [1:0] {
        AT_NONE,
        AT_CELL,
        AT_PAIR
    } attr_mode_t;

endpackage

// File: rtl/pxs_timing.sv
module pxs_timing
    import pxs_pkg::*;
#(
    parameter int LINE_SLOTS = 640,
    parameter int LEAD       = 8,
    parameter int COL_W      = 7,
    parameter int IDX_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_en,
    input  logic [1:0]       scale_sel,
    input  logic [1:0]       attr_sel,
    input  logic [2:0]       row_line,
    output pxs_state_t       state,
    output logic [COL_W-1:0] col,
    output logic [2:0]       bitp,
    output attr_mode_t       mode,
    output logic             fetch_row,
    output logic             load,
    output logic             bm_req,
    output logic             at_req,
    output logic [IDX_W-1:0] at_tgt
);

    localparam int SLOT_W = $clog2(LINE_SLOTS);
    localparam int COLS1  = (LINE_SLOTS - LEAD) / 8;
    localparam int COLS2  = (LINE_SLOTS - LEAD) / 16;
    localparam int COLS3  = (LINE_SLOTS - LEAD) / 24;

    pxs_state_t        nxt;
    logic [SLOT_W-1:0] slot;
    logic [4:0]        off;
    logic [4:0]        per_col;
    logic [1:0]        sub;
    logic [1:0]        scale_q;
    logic              line0_q;
    logic [COL_W-1:0]  ncols;
    logic [COL_W-1:0]  nc;
    logic              col_end, last_col, lead_end, slot_last, fetch_on;

    always_comb begin
        per_col = {scale_q, 3'b000};
        unique case (scale_q)
            2'd1:    ncols = COL_W'(COLS1);
            2'd2:    ncols = COL_W'(COLS2);
            default: ncols = COL_W'(COLS3);
        endcase
        col_end   = (off == per_col - 5'd1);
        last_col  = (col == ncols - COL_W'(1));
        lead_end  = (slot == SLOT_W'(LEAD - 1));
        slot_last = (slot == SLOT_W'(LINE_SLOTS - 1));
        nc        = col + COL_W'(1);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (line_en) nxt = ST_LEAD;
            ST_LEAD:   if (!line_en) nxt = ST_IDLE;
                       else if (lead_end) nxt = ST_ACTIVE;
            ST_ACTIVE: if (!line_en) nxt = ST_IDLE;
                       else if (col_end && last_col) nxt = slot_last ? ST_DONE : ST_PAD;
            ST_PAD:    if (!line_en) nxt = ST_IDLE;
                       else if (slot_last) nxt = ST_DONE;
            ST_DONE:   if (!line_en) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // slot, column and pixel counters; line configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot    <= '0;
            off     <= '0;
            sub     <= '0;
            bitp    <= '0;
            col     <= '0;
            scale_q <= 2'd1;
            mode    <= AT_NONE;
            line0_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (line_en) begin
                    slot    <= '0;
                    scale_q <= (scale_sel == 2'd0) ? 2'd1 : (scale_sel == 2'd1) ? 2'd2 : 2'd3;
                    mode    <= (scale_sel == 2'd0 || attr_sel == 2'd0) ? AT_NONE :
                               (attr_sel == 2'd1) ? AT_CELL : AT_PAIR;
                    line0_q <= (row_line == 3'd0);
                end
                ST_LEAD: begin
                    slot <= slot + SLOT_W'(1);
                    if (lead_end) begin
                        col  <= '0;
                        off  <= '0;
                        sub  <= '0;
                        bitp <= '0;
                    end
                end
                ST_ACTIVE: begin
                    slot <= slot + SLOT_W'(1);
                    if (col_end) begin
                        col  <= nc;
                        off  <= '0;
                        sub  <= '0;
                        bitp <= '0;
                    end else begin
                        off <= off + 5'd1;
                        if (sub == scale_q - 2'd1) begin
                            sub  <= '0;
                            bitp <= bitp + 3'd1;
                        end else begin
                            sub <= sub + 2'd1;
                        end
                    end
                end
                ST_PAD:  slot <= slot + SLOT_W'(1);
                default: ;
            endcase
        end
    end

    // fetch requests and column load strobe
    always_comb begin
        fetch_on  = (mode != AT_NONE) && line0_q;
        fetch_row = line0_q;
        load      = (state == ST_LEAD && lead_end) ||
                    (state == ST_ACTIVE && col_end && !last_col);
        bm_req    = (state == ST_LEAD && slot == SLOT_W'(LEAD - 4)) ||
                    (state == ST_ACTIVE && off == per_col - 5'd4 && !last_col);
        at_req    = fetch_on &&
                    ((state == ST_LEAD && slot == '0) ||
                     (state == ST_ACTIVE && off == per_col - 5'd8 && !last_col &&
                      (mode == AT_CELL || col[0])));
        if (state == ST_LEAD)      at_tgt = '0;
        else if (mode == AT_CELL)  at_tgt = IDX_W'(nc);
        else                       at_tgt = IDX_W'(nc >> 1);
    end

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) == ST_ACTIVE && sub != 2'd0) |-> $stable(bitp));

    p_col_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> (col < ncols));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (state == ST_IDLE));

endmodule

// File: rtl/pxs_attr_buf.sv
module pxs_attr_buf #(
    parameter int DEPTH = 40,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && int'(wr_idx) < DEPTH) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : 8'h00;

    p_wr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH));

endmodule

// File: rtl/pxs_color.sv
module pxs_color
    import pxs_pkg::*;
(
    input  logic       active,
    input  logic       pix_bit,
    input  attr_mode_t mode,
    input  logic       odd_col,
    input  logic [7:0] attr,
    output logic [3:0] pix
);

    always_comb begin
        pix = 4'd0;
        if (active) begin
            unique case (mode)
                AT_CELL: pix = pix_bit ? attr[7:4] : attr[3:0];
                AT_PAIR: pix = pix_bit ? (odd_col ? attr[3:0] : attr[7:4]) : 4'd0;
                default: pix = {3'b000, pix_bit};
            endcase
        end
    end

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pxs_pkg::*;
#(
    parameter int LINE_SLOTS = 640,
    parameter int LEAD       = 8,
    parameter int BUF_DEPTH  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_en,
    input  logic [1:0] scale_sel,
    input  logic [1:0] attr_sel,
    input  logic [2:0] row_line,
    input  logic       bm_stb,
    input  logic [7:0] bm_byte,
    input  logic       at_stb,
    input  logic [7:0] at_byte,
    output logic [3:0] pix_idx,
    output logic       bm_req,
    output logic       at_req
);

    localparam int COL_W = $clog2((LINE_SLOTS - LEAD) / 8 + 1);
    localparam int IDX_W = $clog2(BUF_DEPTH);

    pxs_state_t       state;
    attr_mode_t       mode;
    logic [COL_W-1:0] col;
    logic [2:0]       bitp;
    logic             fetch_row, load;
    logic [IDX_W-1:0] at_tgt, at_wr_idx, rd_idx;
    logic [7:0]       next_bm, cur_bm, attr;

    pxs_timing #(
        .LINE_SLOTS(LINE_SLOTS), .LEAD(LEAD), .COL_W(COL_W), .IDX_W(IDX_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .line_en(line_en),
        .scale_sel(scale_sel), .attr_sel(attr_sel), .row_line(row_line),
        .state(state), .col(col), .bitp(bitp), .mode(mode),
        .fetch_row(fetch_row), .load(load),
        .bm_req(bm_req), .at_req(at_req), .at_tgt(at_tgt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_bm   <= '0;
            cur_bm    <= '0;
            at_wr_idx <= '0;
        end else begin
            if (bm_stb) next_bm   <= bm_byte;
            if (load)   cur_bm    <= next_bm;
            if (at_req) at_wr_idx <= at_tgt;
        end
    end

    assign rd_idx = (mode == AT_CELL) ? IDX_W'(col) : IDX_W'(col >> 1);

    pxs_attr_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(at_stb && fetch_row), .wr_idx(at_wr_idx), .wr_data(at_byte),
        .rd_idx(rd_idx), .rd_data(attr)
    );

    pxs_color u_color (
        .active(state == ST_ACTIVE), .pix_bit(cur_bm[3'd7 - bitp]),
        .mode(mode), .odd_col(col[0]), .attr(attr), .pix(pix_idx)
    );

    p_lead_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> (pix_idx == 4'd0));

    p_tail_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD || state == ST_DONE) |-> (pix_idx == 4'd0 && !bm_req && !at_req));

    p_plain_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AT_NONE) |-> (pix_idx[3:1] == 3'd0));

    p_req_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_req && at_req));

endmodule

// File: tb/pixel_serializer_bench.sv
module pixel_serializer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_en = 1'b0;
    logic [1:0] scale_sel = 2'd0;
    logic [1:0] attr_sel = 2'd0;
    logic [2:0] row_line = 3'd0;
    logic       bm_stb = 1'b0;
    logic [7:0] bm_byte = 8'd0;
    logic       at_stb = 1'b0;
    logic [7:0] at_byte = 8'd0;
    logic [3:0] pix_idx;
    logic       bm_req, at_req;

    int checks = 0;
    int errors = 0;
    int attr_exp [40];

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_serializer u_pixel_serializer (
        .clk(clk), .rst_n(rst_n), .line_en(line_en),
        .scale_sel(scale_sel), .attr_sel(attr_sel), .row_line(row_line),
        .bm_stb(bm_stb), .bm_byte(bm_byte), .at_stb(at_stb), .at_byte(at_byte),
        .pix_idx(pix_idx), .bm_req(bm_req), .at_req(at_req)
    );

    function automatic int bmf(int c, int line, int cfg);
        return (c * 37 + line * 53 + cfg * 11 + 91) & 255;
    endfunction

    function automatic int atf(int k, int cfg);
        return (k * 73 + cfg * 29 + 17) & 255;
    endfunction

    task automatic chk(input string tag, input int s, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s slot %0d actual %0d expected %0d", tag, s, act, exp);
        end
    endtask

    task automatic quiet_check(input string tag);
        chk(tag, -1, int'(pix_idx), 0);
        chk(tag, -1, int'(bm_req), 0);
        chk(tag, -1, int'(at_req), 0);
    endtask

    // one line: sc_sel/at_sel raw inputs, hold = slots with line_en high
    task automatic run_line(input int sc_sel, input int at_sel, input int line,
                            input int hold, input bit spur, input int cfg);
        int sc, am, per, cols, bm_k, at_k, exp_at_n;
        bit pend_bm, pend_at;
        int pend_bm_d, pend_at_d;
        bit fetch;
        sc   = (sc_sel == 0) ? 1 : (sc_sel == 1) ? 2 : 3;
        am   = (sc == 1) ? 0 : (at_sel == 0) ? 0 : (at_sel == 1) ? 1 : 2;
        per  = 8 * sc;
        cols = 632 / per;
        fetch = (am != 0) && (line == 0);
        if (line == 0)
            for (int k = 0; k < 40; k++) attr_exp[k] = atf(k, cfg);
        bm_k = 0; at_k = 0; pend_bm = 0; pend_at = 0; pend_bm_d = 0; pend_at_d = 0;
        @(negedge clk);
        scale_sel = 2'(sc_sel);
        attr_sel  = 2'(at_sel);
        row_line  = 3'(line);
        line_en   = 1'b1;
        for (int s = 0; s < hold; s++) begin
            int c, o, b, a, exp_pix, exp_bm, exp_at;
            string tag;
            @(negedge clk);
            bm_stb  = pend_bm;
            bm_byte = 8'(pend_bm_d);
            at_stb  = pend_at | spur;
            at_byte = pend_at ? 8'(pend_at_d) : 8'(s ^ 8'hA5);
            // expected pixel
            exp_pix = 0;
            if (s < 8) tag = "R3";
            else if (s >= 640 || (s - 8) / per >= cols) tag = "R4";
            else begin
                c = (s - 8) / per;
                o = (s - 8) % per;
                b = (bmf(c, line, cfg) >> (7 - o / sc)) & 1;
                if (am == 0) begin
                    exp_pix = b;
                    tag = (sc_sel == 0 && at_sel != 0) ? "R10" : (sc == 1 ? "R1" : "R2");
                end else if (am == 1) begin
                    a = attr_exp[c];
                    exp_pix = b ? (a >> 4) : (a & 15);
                    tag = (line != 0) ? "R9" : "R7";
                end else begin
                    a = attr_exp[c / 2];
                    exp_pix = b ? ((c % 2 == 0) ? (a >> 4) : (a & 15)) : 0;
                    tag = (line != 0) ? "R9" : "R8";
                end
            end
            chk(tag, s, int'(pix_idx), exp_pix);
            // expected requests (R5 bitmap, R6 attribute)
            exp_bm = (s < 640 && s >= 4 && (s - 4) % per == 0 && (s - 4) / per < cols) ? 1 : 0;
            exp_at = (fetch && s < 640 && s % per == 0 && s / per < cols &&
                      (am == 1 || (s / per) % 2 == 0)) ? 1 : 0;
            chk("R5", s, int'(bm_req), exp_bm);
            chk((sc_sel == 0) ? "R10" : "R6", s, int'(at_req), exp_at);
            // fetcher model
            pend_bm = bm_req;
            if (bm_req) begin pend_bm_d = bmf(bm_k, line, cfg); bm_k++; end
            pend_at = at_req;
            if (at_req) begin pend_at_d = atf(at_k, cfg); at_k++; end
        end
        @(negedge clk);
        line_en = 1'b0;
        bm_stb  = 1'b0;
        at_stb  = 1'b0;
        @(negedge clk);
        quiet_check("R11");
        if (hold >= 640) begin
            exp_at_n = !fetch ? 0 : (am == 1) ? cols : (cols + 1) / 2;
            chk("R5", -1, bm_k, cols);
            chk("R6", -1, at_k, exp_at_n);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired before the run finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        quiet_check("R11");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_check("R11");

        // sweep every width and attribute mode over a full character row
        for (int sc = 0; sc < 3; sc++) begin
            for (int am = 0; am < 3; am++) begin
                for (int ln = 0; ln < 8; ln++) begin
                    run_line(sc, am, ln, 648, (ln == 5), sc * 3 + am);
                end
            end
        end

        // encoding 3 aliases: width x3 and per-pair attributes (R2, R8)
        run_line(3, 3, 0, 648, 1'b0, 20);
        run_line(3, 3, 6, 648, 1'b1, 20);

        // line cut short, then a clean line (R11)
        run_line(1, 1, 0, 100, 1'b0, 30);
        run_line(1, 0, 2, 648, 1'b0, 31);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule